// File: doc/BRIEF.md
# Dual Mode-Selectable Timer/Counter

This peripheral holds two 16-bit count registers, timer A (index 0) and timer B (index 1). Each is stored as a low byte and a high byte. Each timer advances either once per machine cycle or once per falling edge seen on its own external count pin. A machine cycle is a fixed number of clock periods, set by a parameter with a default of 12.

A configuration register gives each timer a 2-bit counting mode, a source select and a gate enable. A control register holds the two run bits and the two overflow flags. Software reads and writes every register through one byte-wide port. A write completes on the clock edge where `reg_wr` is high. A read is combinational from `reg_addr`.

Timer A also offers a split mode. In that mode its two bytes act as two separate 8-bit counters, and the upper one borrows timer B's run bit and overflow flag.

Top module: `twin_tmr`

## Requirements
- R1: Register addresses are 0 = control, 1 = configuration, 2/3 = timer A low/high byte, 4/5 = timer B low/high byte. After reset every register reads 0x00.
- R2: The configuration byte holds timer B in bits 7:4 and timer A in bits 3:0, each nibble laid out as {gate, source, mode[1:0]}. In timer source (source = 0) a running count advances on every clock edge numbered a multiple of 12, counting edges from 1 after reset release. In mode 01 the 16-bit count wraps from 0xFFFF to 0x0000 and sets that timer's flag.
- R3: In mode 00 the count is 13 bits wide: 5 bits in the low byte plus 8 bits in the high byte. The top three bits of the low byte read as 0. Wrapping from 0x1FFF to 0 sets the flag.
- R4: In mode 10 only the low byte counts. When it passes 0xFF it is loaded from the high byte, which stays unchanged, and the flag is set.
- R5: Timer B in mode 11 holds its value and sets no flag, even with its run bit set.
- R6: Timer A in mode 11 splits into two 8-bit counters. The low byte is run by timer A's run bit and gate, and sets timer A's flag on wrap. The high byte counts machine cycles while timer B's run bit is set, and sets timer B's flag on wrap.
- R7: With source = 1 a running count advances once per 1-to-0 transition of its count pin. The pin is sampled once per machine cycle and must hold each level for at least one machine cycle.
- R8: With gate = 1 a timer advances only while its gate pin is high. The pin passes through a two-flop synchronizer first.
- R9: Control bits: 7 = timer B flag, 6 = timer B run, 5 = timer A flag, 4 = timer A run. Bits 3:0 read 0. Run bits read back as written. Writing 0 to a flag bit clears it.
- R10: A write to a timer's count byte wins over that timer's increment in the same cycle. That increment is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ext_cnt0 | input | 1 | Count pin, timer A |
| ext_cnt1 | input | 1 | Count pin, timer B |
| ext_gate0 | input | 1 | Gate pin, timer A |
| ext_gate1 | input | 1 | Gate pin, timer B |

## Verification
Any fault in the prescaler phase, the carry chain, the 13-bit masking or the reload path changes the count value that software can read. It also moves the overflow flag. The error becomes visible within one machine cycle of the faulty increment, so every window read is compared against an arithmetic model of the tick count. Because the count keeps running, a wrong register state stays visible until software rewrites it.

Split-mode and gating faults show up as a byte that moves when it should hold. They can also show up as a flag raised in the wrong control bit. Write-priority faults show up as an off-by-one read just after a write placed on a tick edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MD_13B   = 2'b00,
    MD_16B   = 2'b01,
    MD_RLD8  = 2'b10,
    MD_SPLIT = 2'b11
  } tmr_mode_e;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_CFG  = 3'd1;
  localparam logic [2:0] RA_T0L  = 3'd2;
  localparam logic [2:0] RA_T0H  = 3'd3;
  localparam logic [2:0] RA_T1L  = 3'd4;
  localparam logic [2:0] RA_T1H  = 3'd5;

  // byte increment with carry out in bit 8
  function automatic logic [8:0] inc8(input logic [7:0] v);
    return {1'b0, v} + 9'd1;
  endfunction

  // 5-bit increment with carry out in bit 5 (13-bit mode low part)
  function automatic logic [5:0] inc5(input logic [4:0] v);
    return {1'b0, v} + 6'd1;
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pc <= '0;
    else if (pc == LAST) pc <= '0;
    else                 pc <= pc + 1'b1;
  end

  assign tick = (pc == LAST);

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick); // R2

endmodule

// File: rtl/tmr_pin_sense.sv
module tmr_pin_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cnt_pin,
  input  logic gate_pin,
  output logic fall,
  output logic gate_lvl
);
  logic [1:0] cnt_s;
  logic [1:0] gate_s;
  logic       smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_s  <= '0;
      gate_s <= '0;
      smp    <= 1'b0;
    end else begin
      cnt_s  <= {cnt_s[0], cnt_pin};
      gate_s <= {gate_s[0], gate_pin};
      if (tick) smp <= cnt_s[1];
    end
  end

  // level seen high at the previous machine cycle, low at this one
  assign fall     = tick & smp & ~cnt_s[1];
  assign gate_lvl = gate_s[1];

  AST_FALL_SPACED: assert property (@(posedge clk) disable iff (!rst_n) fall |=> !fall); // R7

endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit #(
  parameter bit SPLIT_CAPABLE = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  tmr_pkg::tmr_mode_e  mode,
  input  logic                inc_lo,
  input  logic                inc_hi,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [7:0]          wdata,
  output logic [7:0]          lo_rd,
  output logic [7:0]          hi_rd,
  output logic                ovf_lo,
  output logic                ovf_hi
);
  import tmr_pkg::*;

  logic [7:0] lo_q, hi_q, lo_n, hi_n;
  logic [8:0] lo_p1, hi_p1;
  logic [5:0] lo5_p1;
  logic       wr_any;

  assign lo_p1  = inc8(lo_q);
  assign hi_p1  = inc8(hi_q);
  assign lo5_p1 = inc5(lo_q[4:0]);
  assign wr_any = wr_lo | wr_hi;

  always_comb begin
    lo_n   = lo_q;
    hi_n   = hi_q;
    ovf_lo = 1'b0;
    ovf_hi = 1'b0;
    case (mode)
      MD_13B: if (inc_lo && !wr_any) begin
        lo_n = {3'b000, lo5_p1[4:0]};
        if (lo5_p1[5]) begin
          hi_n   = hi_p1[7:0];
          ovf_lo = hi_p1[8];
        end
      end
      MD_16B: if (inc_lo && !wr_any) begin
        lo_n = lo_p1[7:0];
        if (lo_p1[8]) begin
          hi_n   = hi_p1[7:0];
          ovf_lo = hi_p1[8];
        end
      end
      MD_RLD8: if (inc_lo && !wr_any) begin
        if (lo_p1[8]) begin
          lo_n   = hi_q;
          ovf_lo = 1'b1;
        end else begin
          lo_n = lo_p1[7:0];
        end
      end
      MD_SPLIT: if (SPLIT_CAPABLE) begin
        if (inc_lo && !wr_lo) begin
          lo_n   = lo_p1[7:0];
          ovf_lo = lo_p1[8];
        end
        if (inc_hi && !wr_hi) begin
          hi_n   = hi_p1[7:0];
          ovf_hi = hi_p1[8];
        end
      end
      default: ;
    endcase
    if (wr_lo) lo_n = wdata;
    if (wr_hi) hi_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo_rd = (mode == MD_13B) ? {3'b000, lo_q[4:0]} : lo_q;
  assign hi_rd = hi_q;

  AST_RELOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RLD8 && ovf_lo) |=> lo_q == $past(hi_q)); // R4
  AST_WRAP16: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_16B && ovf_lo) |=> (lo_q == 8'h00 && hi_q == 8'h00)); // R2
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> lo_q == $past(wdata)); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_lo && !inc_hi && !wr_any) |=> ($stable(lo_q) && $stable(hi_q))); // R8

endmodule

// File: rtl/twin_tmr.sv
module twin_tmr #(
  parameter int CYCLE_DIV = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ext_cnt0,
  input  logic       ext_cnt1,
  input  logic       ext_gate0,
  input  logic       ext_gate1
);
  import tmr_pkg::*;

  localparam int NT = 2;

  logic          tick;
  logic [NT-1:0] cnt_pins, gate_pins, fall, glvl;
  logic [3:0]    cfg [NT];
  logic [NT-1:0] tr, tf, tf_set;
  logic [NT-1:0] run, inc_lo, inc_hi, wr_lo, wr_hi, ovf_lo, ovf_hi;
  logic [7:0]    lo_rd [NT];
  logic [7:0]    hi_rd [NT];
  logic          wr_ctrl, wr_cfg, split0;

  tmr_prescale #(.DIV(CYCLE_DIV)) u_pre (.clk(clk), .rst_n(rst_n), .tick(tick));

  assign cnt_pins  = {ext_cnt1, ext_cnt0};
  assign gate_pins = {ext_gate1, ext_gate0};
  assign wr_ctrl   = reg_wr && (reg_addr == RA_CTRL);
  assign wr_cfg    = reg_wr && (reg_addr == RA_CFG);
  assign split0    = (cfg[0][1:0] == MD_SPLIT);

  genvar i;
  generate
    for (i = 0; i < NT; i++) begin : g_tmr
      tmr_pin_sense u_pin (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cnt_pin(cnt_pins[i]), .gate_pin(gate_pins[i]),
        .fall(fall[i]), .gate_lvl(glvl[i])
      );

      assign wr_lo[i]  = reg_wr && (reg_addr == 3'(RA_T0L + 2 * i));
      assign wr_hi[i]  = reg_wr && (reg_addr == 3'(RA_T0H + 2 * i));
      assign run[i]    = tr[i] & (~cfg[i][3] | glvl[i]);
      assign inc_lo[i] = run[i] & (cfg[i][2] ? fall[i] : tick);

      tmr_count_unit #(.SPLIT_CAPABLE(i == 0)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .mode(tmr_mode_e'(cfg[i][1:0])),
        .inc_lo(inc_lo[i]), .inc_hi(inc_hi[i]),
        .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(reg_wdata),
        .lo_rd(lo_rd[i]), .hi_rd(hi_rd[i]),
        .ovf_lo(ovf_lo[i]), .ovf_hi(ovf_hi[i])
      );
    end
  endgenerate

  // upper half of split timer A borrows timer B's run bit
  assign inc_hi[0] = tr[1] & tick;
  assign inc_hi[1] = 1'b0;

  assign tf_set[0] = ovf_lo[0];
  assign tf_set[1] = split0 ? ovf_hi[0] : (ovf_lo[1] | ovf_hi[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg[0] <= '0;
      cfg[1] <= '0;
      tr     <= '0;
      tf     <= '0;
    end else begin
      if (wr_cfg) begin
        cfg[1] <= reg_wdata[7:4];
        cfg[0] <= reg_wdata[3:0];
      end
      if (wr_ctrl) tr <= {reg_wdata[6], reg_wdata[4]};
      tf[0] <= tf_set[0] | (wr_ctrl ? reg_wdata[5] : tf[0]);
      tf[1] <= tf_set[1] | (wr_ctrl ? reg_wdata[7] : tf[1]);
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = {tf[1], tr[1], tf[0], tr[0], 4'b0000};
      RA_CFG:  reg_rdata = {cfg[1], cfg[0]};
      RA_T0L:  reg_rdata = lo_rd[0];
      RA_T0H:  reg_rdata = hi_rd[0];
      RA_T1L:  reg_rdata = lo_rd[1];
      RA_T1H:  reg_rdata = hi_rd[1];
      default: reg_rdata = 8'h00;
    endcase
  end

  AST_TF0_SET: assert property (@(posedge clk) disable iff (!rst_n) tf_set[0] |=> tf[0]); // R9
  AST_T1_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[1][1:0] == MD_SPLIT && !wr_lo[1] && !wr_hi[1] && !wr_cfg)
      |=> ($stable(lo_rd[1]) && $stable(hi_rd[1]))); // R5
  AST_SPLIT_TF1: assert property (@(posedge clk) disable iff (!rst_n)
    (split0 && ovf_hi[0]) |=> tf[1]); // R6

endmodule

// File: tb/twin_tmr_tb.sv
module twin_tmr_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ext_cnt0 = 1'b1, ext_cnt1 = 1'b1, ext_gate0 = 1'b0, ext_gate1 = 1'b0;

  int n_chk = 0, n_bad = 0, ecnt = 0, cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  twin_tmr dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_cnt0(ext_cnt0),
    .ext_cnt1(ext_cnt1), .ext_gate0(ext_gate0), .ext_gate1(ext_gate1)
  );

  always @(posedge clk) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d, output int k);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    k = ecnt;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // ticks on edges k (multiples of 12) inside (ks, kp]
  function automatic int nticks(input int ks, input int kp);
    return kp / 12 - ks / 12;
  endfunction

  function automatic void adv(input int md, input int n, inout int lo, inout int hi, output int ov);
    int v;
    ov = 0;
    if (md == 0) begin
      v = hi * 32 + (lo % 32) + n; ov = (v >= 8192) ? 1 : 0; v = v % 8192;
      lo = v % 32; hi = v / 32;
    end else if (md == 1) begin
      v = hi * 256 + lo + n; ov = (v >= 65536) ? 1 : 0; v = v % 65536;
      lo = v % 256; hi = v / 256;
    end else begin
      if (lo + n <= 255) lo = lo + n;
      else begin lo = hi + ((lo + n - 256) % (256 - hi)); ov = 1; end
    end
  endfunction

  initial begin
    int k, ks, kp, n, elo, ehi, ov;
    logic [7:0] d, d2, d3;
    string tg;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    @(negedge clk);
    for (int a = 0; a < 6; a++) begin
      rreg(3'(a), d);
      chk("R1 reset", d, 0);
    end

    // R9: run bits read back, flags clear on write 0
    wreg(3'd0, 8'h50, k);
    rreg(3'd0, d); chk("R9 run readback", d, 8'h50);
    wreg(3'd0, 8'h00, k);

    // R2 R3 R4: sweep modes, timers, start values
    for (int t = 0; t < 2; t++) begin
      for (int m = 0; m < 3; m++) begin
        for (int s = 0; s < 4; s++) begin
          elo = 248 + s; ehi = 255 - 3 * s;
          wreg(3'd1, (t == 1) ? 8'(m << 4) : 8'(m), k);
          wreg(3'd0, 8'h00, k);
          wreg(3'(2 + 2 * t), 8'(elo), k);
          wreg(3'(3 + 2 * t), 8'(ehi), k);
          wreg(3'd0, (t == 1) ? 8'h40 : 8'h10, ks);
          repeat (100 + 13 * s) @(negedge clk);
          kp = ecnt;
          rreg(3'(2 + 2 * t), d); rreg(3'(3 + 2 * t), d2); rreg(3'd0, d3);
          n = nticks(ks, kp);
          adv(m, n, elo, ehi, ov);
          tg = (m == 0) ? "R3 13-bit" : (m == 1) ? "R2 16-bit" : "R4 reload";
          chk(tg, d, elo);
          chk(tg, d2, ehi);
          chk({tg, " flag"}, (t == 1) ? int'(d3[7]) : int'(d3[5]), ov);
          wreg(3'd0, 8'h00, k);
        end
      end
    end

    // R9: flag clear after an overflow
    wreg(3'd1, 8'h01, k);
    wreg(3'd2, 8'hFF, k); wreg(3'd3, 8'hFF, k);
    wreg(3'd0, 8'h10, k);
    repeat (30) @(negedge clk);
    rreg(3'd0, d); chk("R9 flag set", d[5], 1);
    wreg(3'd0, 8'h00, k);
    rreg(3'd0, d); chk("R9 flag cleared", d, 0);

    // R5: timer B mode 11 frozen
    wreg(3'd1, 8'h30, k);
    wreg(3'd4, 8'h55, k); wreg(3'd5, 8'hAA, k);
    wreg(3'd0, 8'h40, k);
    repeat (100) @(negedge clk);
    rreg(3'd4, d); chk("R5 hold low", d, 8'h55);
    rreg(3'd5, d); chk("R5 hold high", d, 8'hAA);
    rreg(3'd0, d); chk("R5 no flag", d[7], 0);
    wreg(3'd0, 8'h00, k);

    // R6: split timer A
    wreg(3'd1, 8'h03, k);
    wreg(3'd2, 8'hFE, k); wreg(3'd3, 8'hFC, k);
    wreg(3'd0, 8'h10, ks);
    repeat (60) @(negedge clk);
    kp = ecnt;
    n = nticks(ks, kp);
    rreg(3'd2, d); chk("R6 low counts", d, (254 + n) % 256);
    rreg(3'd3, d); chk("R6 high idle", d, 8'hFC);
    rreg(3'd0, d); chk("R6 TF0", d[5], (254 + n > 255) ? 1 : 0);
    chk("R6 TF1 idle", d[7], 0);
    wreg(3'd0, 8'h40, kp);
    elo = (254 + nticks(ks, kp)) % 256;
    ks = kp;
    repeat (80) @(negedge clk);
    kp = ecnt;
    n = nticks(ks, kp);
    rreg(3'd2, d); chk("R6 low stopped", d, elo);
    rreg(3'd3, d); chk("R6 high counts", d, (252 + n) % 256);
    rreg(3'd0, d); chk("R6 TF1", d[7], (252 + n > 255) ? 1 : 0);
    wreg(3'd0, 8'h00, k);

    // R7: counter source on falling edges
    wreg(3'd1, 8'h05, k);
    wreg(3'd2, 8'h00, k); wreg(3'd3, 8'h00, k);
    wreg(3'd0, 8'h10, k);
    for (int p = 0; p < 5; p++) begin
      ext_cnt0 = 1'b0; repeat (30) @(negedge clk);
      ext_cnt0 = 1'b1; repeat (30) @(negedge clk);
    end
    rreg(3'd2, d); chk("R7 edge count", d, 5);
    rreg(3'd3, d); chk("R7 edge count high", d, 0);
    wreg(3'd0, 8'h00, k);

    // R8: gate
    wreg(3'd1, 8'h09, k);
    wreg(3'd2, 8'h00, k); wreg(3'd3, 8'h00, k);
    wreg(3'd0, 8'h10, k);
    repeat (100) @(negedge clk);
    rreg(3'd2, d); chk("R8 gated off", d, 0);
    ext_gate0 = 1'b1;
    ks = ecnt + 2;
    repeat (90) @(negedge clk);
    kp = ecnt;
    rreg(3'd2, d); chk("R8 gated on", d, nticks(ks, kp));
    wreg(3'd0, 8'h00, k);
    ext_gate0 = 1'b0;

    // R10: write on a tick edge wins
    wreg(3'd1, 8'h01, k);
    wreg(3'd2, 8'h00, k); wreg(3'd3, 8'h00, k);
    wreg(3'd0, 8'h10, k);
    @(negedge clk);
    while (ecnt % 12 != 11) @(negedge clk);
    reg_addr = 3'd2; reg_wdata = 8'h40; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    rreg(3'd2, d); chk("R10 write wins", d, 8'h40);
    rreg(3'd3, d); chk("R10 high kept", d, 0);
    repeat (12) @(negedge clk);
    rreg(3'd2, d); chk("R10 next tick", d, 8'h41);
    wreg(3'd0, 8'h00, k);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule